// File: doc/BRIEF.md
# Conversion Start and Done-Flag Controller

This block sits between the serial command port of a converter and its conversion engine. The port hands it decoded command bytes, register-read strobes and configuration writes. From these the block decides when a single conversion begins, keeps the conversion-done flag that software polls, and drives four general-purpose latch pins from the top nibble of the configuration word. When the flag-mode bit is set, a finished conversion also raises a request to the serial port, which then drives its data output low as a ready signal. The request stays up until the host starts its next command byte.

The conversion engine is modelled here as a down-counter of `CONV_LEN` clock cycles. A restart pulse goes to the engine for every accepted start. A start that arrives while a conversion is running throws away the conversion in progress and begins a new one. The done flag is cleared only by reads of the result and calibration registers. Reading the configuration word, which holds the flag, leaves it as it is.

Top module: `cnv_flag_ctrl`

## Requirements
- R1: A conversion starts only on a command byte equal to 8'hC0, where bit 7 is the command marker, bit 6 is the single-conversion bit and every other bit is 0. Any other byte starts nothing.
- R2: After the clock edge that accepts a start, `busy` is high for exactly `CONV_LEN` cycles. `doneFlag` goes high on the same edge that drops `busy`.
- R3: A read strobe with `rdSel` equal to 1 (data), 2 (gain), 3 (offset) or 4 (setup) clears `doneFlag` on the following edge.
- R4: A read strobe with `rdSel` equal to 0 (configuration) leaves `doneFlag` unchanged.
- R5: When a conversion completes in the same cycle as a clearing read, `doneFlag` ends up set.
- R6: A start accepted while `busy` is high reloads the conversion, so completion comes `CONV_LEN` cycles after the latest start. `restartPulse` is high for the one cycle after every accepted start.
- R7: `latchOut[3:0]` equals bits 23 to 20 of the configuration word, starting one cycle after the write.
- R8: When configuration bit 9 (flag mode) is 1, completion raises `flagReq` on the edge that sets `doneFlag`. When bit 9 is 0, completion leaves `flagReq` low.
- R9: Any command byte strobe clears `flagReq` on the next edge, unless a flag-mode completion happens in that same cycle.
- R10: After reset, `busy`, `doneFlag`, `flagReq`, `restartPulse` and `latchOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Strobe marking the start of a command byte |
| cmdByte | input | 8 | Command byte value |
| rdValid | input | 1 | Register-read strobe |
| rdSel | input | 3 | Register being read: 0 config, 1 data, 2 gain, 3 offset, 4 setup |
| cfgWrValid | input | 1 | Configuration write strobe |
| cfgWrData | input | CFG_W | Configuration word being written |
| restartPulse | output | 1 | One-cycle restart request to the conversion engine |
| busy | output | 1 | Conversion in progress |
| doneFlag | output | 1 | Conversion-done flag |
| flagReq | output | 1 | Request to pull the serial output low as a ready indication |
| latchOut | output | LATCH_W | General-purpose latch pins |

## Verification
All outputs are registered, so every stimulus shows up exactly one edge after the edge that samples it. `restartPulse`, `busy`, the latch pins, clears of `doneFlag` and clears of `flagReq` all appear one cycle after their strobe. Completion comes `CONV_LEN` edges after the last accepted start. The bench drives inputs on the falling edge and updates a bench-side cycle model on each rising edge. It compares every output on the following falling edge, so every check sees exactly the cycle in which a result is due. Directed sequences place clearing reads, configuration reads and repeated starts on the exact completion cycle.

// File: rtl/cnv_pkg.sv
package cnv_pkg;

  localparam logic [7:0] CMD_START = 8'hC0;

  typedef enum logic [2:0] {
    RD_CFG   = 3'd0,
    RD_DATA  = 3'd1,
    RD_GAIN  = 3'd2,
    RD_OFFS  = 3'd3,
    RD_SETUP = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic startConv;
    logic clrDone;
    logic cfgLoad;
    logic cmdBegin;
  } cnvStrobe_t;

endpackage

// File: rtl/cnv_ctrl.sv
module cnv_ctrl
  import cnv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       rdValid,
  input  logic [2:0] rdSel,
  input  logic       cfgWrValid,
  output cnvStrobe_t stb
);

  logic isClearingSel;

  always_comb begin
    unique case (rdSel)
      RD_DATA, RD_GAIN, RD_OFFS, RD_SETUP: isClearingSel = 1'b1;
      default:                             isClearingSel = 1'b0;
    endcase
  end

  always_comb begin
    stb.startConv = cmdValid && (cmdByte == CMD_START);
    stb.cmdBegin  = cmdValid;
    stb.clrDone   = rdValid && isClearingSel;
    stb.cfgLoad   = cfgWrValid;
  end

  // R1: a strobe that is not an exact start byte never asks for a conversion
  a_r1_exact_start: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdByte != CMD_START) |-> !stb.startConv);

  // R4: a configuration read never turns into a clear
  a_r4_cfg_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdSel == RD_CFG) |-> !stb.clrDone);

endmodule

// File: rtl/cnv_datapath.sv
module cnv_datapath
  import cnv_pkg::*;
#(
  parameter int CONV_LEN  = 16,
  parameter int CFG_W     = 24,
  parameter int LATCH_W   = 4,
  parameter int LATCH_LSB = 20,
  parameter int FLAG_BIT  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  cnvStrobe_t         stb,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic               restartPulse,
  output logic               busy,
  output logic               doneFlag,
  output logic               flagReq,
  output logic [LATCH_W-1:0] latchOut
);

  localparam int CNT_W = (CONV_LEN > 2) ? $clog2(CONV_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic [CFG_W-1:0] cfgReg;
  logic             compPulse;
  logic             flagMode;

  assign flagMode  = cfgReg[FLAG_BIT];
  assign compPulse = busy && (cnt == '0) && !stb.startConv;

  // conversion engine model: down-counter reloaded by every start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      cnt          <= '0;
      restartPulse <= 1'b0;
    end else begin
      restartPulse <= stb.startConv;
      if (stb.startConv) begin
        busy <= 1'b1;
        cnt  <= CNT_LOAD;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  // done flag: setting beats clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             doneFlag <= 1'b0;
    else if (compPulse)    doneFlag <= 1'b1;
    else if (stb.clrDone)  doneFlag <= 1'b0;
  end

  // ready request to the serial port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        flagReq <= 1'b0;
    else if (compPulse && flagMode)   flagReq <= 1'b1;
    else if (stb.cmdBegin)            flagReq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgReg <= '0;
    else if (stb.cfgLoad) cfgReg <= cfgWrData;
  end

  for (genvar i = 0; i < LATCH_W; i++) begin : g_latch
    assign latchOut[i] = cfgReg[LATCH_LSB + i];
  end

  a_r2_done_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    compPulse |=> (doneFlag && !busy));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrDone && !compPulse) |=> !doneFlag);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (compPulse && stb.clrDone) |=> doneFlag);

  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    stb.startConv |=> (busy && restartPulse));

  a_r8_no_req_without_mode: assert property (@(posedge clk) disable iff (!rstN)
    (!flagReq && !(compPulse && flagMode)) |=> !flagReq);

  a_r9_req_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmdBegin && !(compPulse && flagMode)) |=> !flagReq);

endmodule

// File: rtl/cnv_flag_ctrl.sv
module cnv_flag_ctrl
  import cnv_pkg::*;
#(
  parameter int CONV_LEN  = 16,
  parameter int CFG_W     = 24,
  parameter int LATCH_W   = 4,
  parameter int LATCH_LSB = 20,
  parameter int FLAG_BIT  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [7:0]         cmdByte,
  input  logic               rdValid,
  input  logic [2:0]         rdSel,
  input  logic               cfgWrValid,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic               restartPulse,
  output logic               busy,
  output logic               doneFlag,
  output logic               flagReq,
  output logic [LATCH_W-1:0] latchOut
);

  cnvStrobe_t stb;

  cnv_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdByte    (cmdByte),
    .rdValid    (rdValid),
    .rdSel      (rdSel),
    .cfgWrValid (cfgWrValid),
    .stb        (stb)
  );

  cnv_datapath #(
    .CONV_LEN  (CONV_LEN),
    .CFG_W     (CFG_W),
    .LATCH_W   (LATCH_W),
    .LATCH_LSB (LATCH_LSB),
    .FLAG_BIT  (FLAG_BIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cfgWrData    (cfgWrData),
    .restartPulse (restartPulse),
    .busy         (busy),
    .doneFlag     (doneFlag),
    .flagReq      (flagReq),
    .latchOut     (latchOut)
  );

  a_r7_latch_follow: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrValid |=> (latchOut == $past(cfgWrData[LATCH_LSB +: LATCH_W])));

  a_r4_port_cfg_read: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && rdValid && rdSel == 3'd0) |=> doneFlag);

endmodule

// File: tb/cnv_flag_ctrl_tb.sv
`timescale 1ns/1ps
module cnv_flag_ctrl_tb;

  localparam int CONV_LEN = 16;
  localparam int CFG_W    = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [7:0]       cmdByte = '0;
  logic             rdValid = 1'b0;
  logic [2:0]       rdSel = '0;
  logic             cfgWrValid = 1'b0;
  logic [CFG_W-1:0] cfgWrData = '0;
  logic             restartPulse, busy, doneFlag, flagReq;
  logic [3:0]       latchOut;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string phase = "R10";

  // bench-side model state
  bit             mBusy, mDone, mReq, mRestart;
  int             mCnt;
  logic [CFG_W-1:0] mCfg;

  always #2.5 clk = ~clk;

  cnv_flag_ctrl #(.CONV_LEN(CONV_LEN)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .rdValid(rdValid), .rdSel(rdSel), .cfgWrValid(cfgWrValid),
    .cfgWrData(cfgWrData), .restartPulse(restartPulse), .busy(busy),
    .doneFlag(doneFlag), .flagReq(flagReq), .latchOut(latchOut)
  );

  function automatic bit isStart(logic v, logic [7:0] b);
    return v && (b == 8'hC0);
  endfunction

  function automatic bit isClear(logic v, logic [2:0] s);
    return v && (s >= 3'd1) && (s <= 3'd4);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic modelStep();
    bit st, cl, comp;
    st   = isStart(cmdValid, cmdByte);
    cl   = isClear(rdValid, rdSel);
    comp = mBusy && (mCnt == 0) && !st;
    if (comp) mDone = 1'b1;
    else if (cl) mDone = 1'b0;
    if (comp && mCfg[9]) mReq = 1'b1;
    else if (cmdValid) mReq = 1'b0;
    mRestart = st;
    if (st) begin mBusy = 1'b1; mCnt = CONV_LEN - 1; end
    else if (mBusy) begin
      if (mCnt == 0) mBusy = 1'b0; else mCnt--;
    end
    if (cfgWrValid) mCfg = cfgWrData;
  endtask

  task automatic compareAll();
    chk({phase, " restartPulse"}, int'(restartPulse), int'(mRestart));
    chk({phase, " busy"},         int'(busy),         int'(mBusy));
    chk({phase, " doneFlag"},     int'(doneFlag),     int'(mDone));
    chk({phase, " flagReq"},      int'(flagReq),      int'(mReq));
    chk({phase, " latchOut"},     int'(latchOut),     int'(mCfg[23:20]));
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    cmdValid = 1'b0; rdValid = 1'b0; cfgWrValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sendCmd(logic [7:0] b);
    cmdValid = 1'b1; cmdByte = b; tick();
  endtask

  task automatic writeCfg(logic [CFG_W-1:0] d);
    cfgWrValid = 1'b1; cfgWrData = d; tick();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      finish();
    end
  end

  initial begin
    void'($urandom(32'd5525));
    mBusy = 0; mDone = 0; mReq = 0; mRestart = 0; mCnt = 0; mCfg = '0;
    repeat (3) @(negedge clk);
    // R10: reset values
    phase = "R10";
    compareAll();
    rstN = 1'b1;
    idle(2);

    // R1: non-start bytes do nothing
    phase = "R1";
    sendCmd(8'hC1); sendCmd(8'h40); sendCmd(8'h80); sendCmd(8'hE0); sendCmd(8'h00);
    idle(2);
    chk("R1 busy after non-start bytes", int'(busy), 0);

    // R2 + R4 + R3: plain conversion, config read keeps flag, data read clears it
    phase = "R2";
    sendCmd(8'hC0);
    chk("R6 restartPulse after start", int'(restartPulse), 1);
    idle(CONV_LEN - 1);
    chk("R2 busy in last cycle", int'(busy), 1);
    tick();
    chk("R2 done at completion", int'(doneFlag), 1);
    chk("R2 busy dropped", int'(busy), 0);
    phase = "R4";
    rdValid = 1'b1; rdSel = 3'd0; tick();
    chk("R4 flag kept after config read", int'(doneFlag), 1);
    phase = "R3";
    for (int s = 1; s <= 4; s++) begin
      sendCmd(8'hC0);
      idle(CONV_LEN);
      rdValid = 1'b1; rdSel = 3'(s); tick();
      chk("R3 flag cleared by read", int'(doneFlag), 0);
    end

    // R5: completion and clearing read in the same cycle
    phase = "R5";
    sendCmd(8'hC0);
    idle(CONV_LEN - 1);
    rdValid = 1'b1; rdSel = 3'd1; tick();
    chk("R5 set wins over clear", int'(doneFlag), 1);
    rdValid = 1'b1; rdSel = 3'd2; tick();

    // R6: restart mid-conversion and on the completion cycle
    phase = "R6";
    sendCmd(8'hC0);
    idle(5);
    sendCmd(8'hC0);
    idle(CONV_LEN - 1);
    chk("R6 still busy after restart", int'(busy), 1);
    chk("R6 no early done", int'(doneFlag), 0);
    sendCmd(8'hC0);
    chk("R6 restart on last cycle keeps busy", int'(busy), 1);
    idle(CONV_LEN);
    chk("R6 done after latest start", int'(doneFlag), 1);

    // R7: latch pins
    phase = "R7";
    writeCfg(24'hA00000);
    chk("R7 latch nibble", int'(latchOut), 10);
    writeCfg(24'h5FFFFF);
    chk("R7 latch nibble 2", int'(latchOut), 5);

    // R8/R9: flag mode request
    phase = "R8";
    writeCfg(24'h000200);
    sendCmd(8'hC0);
    idle(CONV_LEN);
    chk("R8 request raised", int'(flagReq), 1);
    phase = "R9";
    sendCmd(8'h12);
    chk("R9 request cleared by command", int'(flagReq), 0);
    phase = "R8";
    writeCfg(24'h000000);
    sendCmd(8'hC0);
    idle(CONV_LEN);
    chk("R8 no request with mode off", int'(flagReq), 0);

    // random mix against the model
    phase = "R9";
    writeCfg(24'h000200);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) begin cmdValid = 1'b1; cmdByte = 8'hC0; end
      else if (r < 20) begin cmdValid = 1'b1; cmdByte = 8'($urandom); end
      rdValid = ($urandom_range(0, 99) < 15);
      rdSel   = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 99) < 3) begin
        cfgWrValid = 1'b1;
        cfgWrData  = 24'($urandom);
      end
      tick();
    end
    finish();
  end

endmodule